// File: doc/BRIEF.md
# Converter Soft-Start and Protection Supervisor

This block decides when a half-bridge power converter may switch and how hard it may drive. It watches three digitised readings: the controller supply, the divided input-line voltage and the die temperature. Each reading passes through its own hysteretic threshold so that noise near a limit cannot make the converter chatter. While every condition is healthy, an internal soft-start accumulator climbs at a programmable rate. Switching is held off through a dead zone at the bottom of the ramp. After that, a maximum-duty ceiling rises linearly from the minimum to the maximum duty and stays at the maximum.

Any fault returns the ramp to zero, so every recovery goes through a full soft start again. A separate comparison between the line reading and the supply blocks only the high-side driver while the line sits too close to the supply. It leaves the ramp and the low-side driver alone. The PWM modulator that follows uses the enable, the inhibit and the duty ceiling.

Top module: `softstart_supervisor`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, switchEn, highSideInhibit and shutdownMode are 0 and dutyCeiling is 0.
- R2: The supply-good condition sets when supplyCode is at or above 880 and clears when it is below 830. Between those codes it holds its previous value. While supply-good is clear, switchEn is 0.
- R3: The line-good condition sets when lineCode is at or above 330 and clears when it is below 300. Between those codes it holds its previous value. While line-good is clear, switchEn is 0.
- R4: shutdownMode goes to 1 when lineCode is below 55 and returns to 0 only when lineCode is at or above 75. While it is 1, switchEn is 0.
- R5: The over-temperature condition sets when tempCode (1 code = 1 degree C) is above 160 and clears when it is below 130. While it is set, switchEn is 0.
- R6: Any of the faults from R2 to R5 resets the soft-start accumulator and the tick divider to zero. After recovery, the dead zone of R8 is passed again from the start.
- R7: While no fault is present, the accumulator adds rampStep once every TICK_DIV (4) cycles and saturates at 800. The first addition happens on the fourth edge after the faults clear.
- R8: switchEn is 1 only when no fault is present and the accumulator is at or above 120. Below 120 lies the dead zone, where switchEn is 0.
- R9: When switchEn is 1, dutyCeiling = 32 + (acc - 120) * 203 / 680 with integer truncation. This gives 32 at an accumulator of 120 and 235 at 800. When switchEn is 0, dutyCeiling is 0.
- R10: highSideInhibit is 1 on the cycle after an edge at which lineCode + 30 > supplyCode, and 0 otherwise. It has no effect on switchEn or on the ramp.
- R11: All threshold conditions and highSideInhibit are registered. A change at the inputs sampled at one edge appears at the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supplyCode | input | 12 | Sampled controller supply, 10 mV per code |
| lineCode | input | 12 | Sampled line-detect voltage, 10 mV per code |
| tempCode | input | 8 | Die temperature, 1 degree C per code |
| rampStep | input | 8 | Soft-start increment added per tick |
| switchEn | output | 1 | Converter switching allowed |
| highSideInhibit | output | 1 | Block high-side drive only |
| dutyCeiling | output | 8 | Maximum duty, 256 = 100 % |
| shutdownMode | output | 1 | Low-power shutdown state |

## Verification
The assertions check the local rules on every cycle. Each hysteresis flag holds inside its band. A clear strobe empties the accumulator. The accumulator only falls on a clear and never exceeds its cap. Tick strobes never come on back-to-back cycles. The enable is never set during shutdown, and the duty ceiling stays inside its range whenever switching is on. Other properties need a whole scenario to show: the exact cycle at which switching starts after the dead zone, the duty value reached along the ramp, a full restart after each kind of fault, and the independence of the high-side inhibit. The bench shows these by comparing all outputs on every cycle against its own model during directed sequences and random sequences.

// File: rtl/ssup_pkg.sv
package ssup_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic runOk;
    logic rampClear;
    logic rampAdvance;
  } ssup_strobe_t;
endpackage

// File: rtl/ssup_hyst.sv
module ssup_hyst #(
  parameter int W         = 12,
  parameter int SET_LVL   = 880,
  parameter int CLR_LVL   = 830,
  parameter bit SET_BELOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sample,
  output logic         flag
);
  localparam logic [W-1:0] SET_C = W'(SET_LVL);
  localparam logic [W-1:0] CLR_C = W'(CLR_LVL);

  logic setCond;
  logic clrCond;

  generate
    if (SET_BELOW) begin : g_low
      assign setCond = sample < SET_C;
      assign clrCond = sample >= CLR_C;
    end else begin : g_high
      assign setCond = sample >= SET_C;
      assign clrCond = sample < CLR_C;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag <= 1'b0;
    else if (!flag && setCond) flag <= 1'b1;
    else if (flag && clrCond)  flag <= 1'b0;
  end

  // R2 R3 R4 R5
  hyst_hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clrCond) |=> flag);
  // R2 R3 R4 R5
  hyst_hold_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !setCond) |=> !flag);
endmodule

// File: rtl/ssup_ctrl.sv
module ssup_ctrl
  import ssup_pkg::*;
#(
  parameter int CODE_W    = 12,
  parameter int TEMP_W    = 8,
  parameter int UV_ON     = 880,
  parameter int UV_OFF    = 830,
  parameter int LINE_ON   = 330,
  parameter int LINE_OFF  = 300,
  parameter int SD_ENTER  = 55,
  parameter int SD_EXIT   = 75,
  parameter int OT_ON     = 160,
  parameter int OT_OFF    = 130,
  parameter int OV_MARGIN = 30,
  parameter int TICK_DIV  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] supplyCode,
  input  logic [CODE_W-1:0] lineCode,
  input  logic [TEMP_W-1:0] tempCode,
  output ssup_strobe_t      strobe,
  output logic              ovFlag,
  output logic              sdFlag
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
  localparam logic [CODE_W:0]  OV_C = (CODE_W+1)'(OV_MARGIN);

  logic uvOk;
  logic lineOk;
  logic otFlag;
  logic [DIV_W-1:0] divQ;
  logic allOk;
  logic tick;

  ssup_hyst #(.W(CODE_W), .SET_LVL(UV_ON), .CLR_LVL(UV_OFF), .SET_BELOW(1'b0))
    u_uv (.clk(clk), .rst_n(rst_n), .sample(supplyCode), .flag(uvOk));
  ssup_hyst #(.W(CODE_W), .SET_LVL(LINE_ON), .CLR_LVL(LINE_OFF), .SET_BELOW(1'b0))
    u_line (.clk(clk), .rst_n(rst_n), .sample(lineCode), .flag(lineOk));
  ssup_hyst #(.W(CODE_W), .SET_LVL(SD_ENTER), .CLR_LVL(SD_EXIT), .SET_BELOW(1'b1))
    u_sd (.clk(clk), .rst_n(rst_n), .sample(lineCode), .flag(sdFlag));
  ssup_hyst #(.W(TEMP_W), .SET_LVL(OT_ON + 1), .CLR_LVL(OT_OFF), .SET_BELOW(1'b0))
    u_ot (.clk(clk), .rst_n(rst_n), .sample(tempCode), .flag(otFlag));

  // Line too close to the supply: high side only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovFlag <= 1'b0;
    else        ovFlag <= ({1'b0, lineCode} + OV_C) > {1'b0, supplyCode};
  end

  assign allOk = uvOk && lineOk && !sdFlag && !otFlag;

  generate
    if (TICK_DIV > 1) begin : g_div
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              divQ <= '0;
        else if (!allOk)         divQ <= '0;
        else if (divQ == DIV_LAST) divQ <= '0;
        else                     divQ <= divQ + 1'b1;
      end
      assign tick = allOk && (divQ == DIV_LAST);

      // R7
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end else begin : g_nodiv
      assign divQ = '0;
      assign tick = allOk;
    end
  endgenerate

  assign strobe.runOk       = allOk;
  assign strobe.rampClear   = !allOk;
  assign strobe.rampAdvance = tick;

  // R6
  clear_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.rampClear && strobe.rampAdvance));
endmodule

// File: rtl/ssup_ramp.sv
module ssup_ramp
  import ssup_pkg::*;
#(
  parameter int RAMP_W     = 12,
  parameter int STEP_W     = 8,
  parameter int DUTY_W     = 8,
  parameter int RAMP_START = 120,
  parameter int RAMP_TOP   = 800,
  parameter int DUTY_MIN   = 32,
  parameter int DUTY_MAX   = 235
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ssup_strobe_t      strobe,
  input  logic [STEP_W-1:0] rampStep,
  output logic              switchEn,
  output logic [DUTY_W-1:0] dutyCeiling
);
  localparam logic [RAMP_W:0]   TOP_C   = (RAMP_W+1)'(RAMP_TOP);
  localparam logic [RAMP_W-1:0] TOP_R   = RAMP_W'(RAMP_TOP);
  localparam logic [RAMP_W-1:0] START_R = RAMP_W'(RAMP_START);
  localparam logic [31:0] SPAN  = 32'(RAMP_TOP - RAMP_START);
  localparam logic [31:0] DSPAN = 32'(DUTY_MAX - DUTY_MIN);
  localparam logic [31:0] DMIN  = 32'(DUTY_MIN);

  logic [RAMP_W-1:0] rampQ;
  logic [RAMP_W:0]   rampSum;
  logic [31:0]       offs;
  logic [31:0]       scaled;

  assign rampSum = {1'b0, rampQ} + (RAMP_W+1)'(rampStep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rampQ <= '0;
    else if (strobe.rampClear)   rampQ <= '0;
    else if (strobe.rampAdvance) rampQ <= (rampSum > TOP_C) ? TOP_R : rampSum[RAMP_W-1:0];
  end

  assign switchEn = strobe.runOk && (rampQ >= START_R);

  always_comb begin
    offs   = 32'(rampQ) - 32'(START_R);
    scaled = (offs * DSPAN) / SPAN + DMIN;
    dutyCeiling = switchEn ? scaled[DUTY_W-1:0] : '0;
  end

  // R7
  ramp_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rampQ <= TOP_R);
  // R6
  ramp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.rampClear |=> rampQ == '0);
  // R7
  ramp_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.rampClear |=> rampQ >= $past(rampQ));
endmodule

// File: rtl/softstart_supervisor.sv
module softstart_supervisor
  import ssup_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int TEMP_W     = 8,
  parameter int STEP_W     = 8,
  parameter int DUTY_W     = 8,
  parameter int RAMP_W     = 12,
  parameter int UV_ON      = 880,
  parameter int UV_OFF     = 830,
  parameter int LINE_ON    = 330,
  parameter int LINE_OFF   = 300,
  parameter int SD_ENTER   = 55,
  parameter int SD_EXIT    = 75,
  parameter int OT_ON      = 160,
  parameter int OT_OFF     = 130,
  parameter int OV_MARGIN  = 30,
  parameter int TICK_DIV   = 4,
  parameter int RAMP_START = 120,
  parameter int RAMP_TOP   = 800,
  parameter int DUTY_MIN   = 32,
  parameter int DUTY_MAX   = 235
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] supplyCode,
  input  logic [CODE_W-1:0] lineCode,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic [STEP_W-1:0] rampStep,
  output logic              switchEn,
  output logic              highSideInhibit,
  output logic [DUTY_W-1:0] dutyCeiling,
  output logic              shutdownMode
);
  localparam logic [DUTY_W-1:0] DMIN_C = DUTY_W'(DUTY_MIN);
  localparam logic [DUTY_W-1:0] DMAX_C = DUTY_W'(DUTY_MAX);

  ssup_strobe_t strobe;
  logic ovFlag;
  logic sdFlag;

  ssup_ctrl #(
    .CODE_W(CODE_W), .TEMP_W(TEMP_W), .UV_ON(UV_ON), .UV_OFF(UV_OFF),
    .LINE_ON(LINE_ON), .LINE_OFF(LINE_OFF), .SD_ENTER(SD_ENTER), .SD_EXIT(SD_EXIT),
    .OT_ON(OT_ON), .OT_OFF(OT_OFF), .OV_MARGIN(OV_MARGIN), .TICK_DIV(TICK_DIV)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .supplyCode(supplyCode), .lineCode(lineCode),
    .tempCode(tempCode), .strobe(strobe), .ovFlag(ovFlag), .sdFlag(sdFlag)
  );

  ssup_ramp #(
    .RAMP_W(RAMP_W), .STEP_W(STEP_W), .DUTY_W(DUTY_W), .RAMP_START(RAMP_START),
    .RAMP_TOP(RAMP_TOP), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)
  ) u_ramp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rampStep(rampStep),
    .switchEn(switchEn), .dutyCeiling(dutyCeiling)
  );

  assign highSideInhibit = ovFlag;
  assign shutdownMode    = sdFlag;

  // R4
  sd_blocks_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdownMode |-> !switchEn);
  // R9
  duty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switchEn |-> (dutyCeiling >= DMIN_C && dutyCeiling <= DMAX_C));
  // R9
  duty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !switchEn |-> dutyCeiling == '0);
endmodule

// File: tb/tb_softstart_supervisor.sv
module tb_softstart_supervisor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] supplyCode = '0;
  logic [11:0] lineCode = '0;
  logic [7:0]  tempCode = '0;
  logic [7:0]  rampStep = '0;
  logic switchEn, highSideInhibit, shutdownMode;
  logic [7:0] dutyCeiling;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  softstart_supervisor dut (
    .clk(clk), .rst_n(rst_n), .supplyCode(supplyCode), .lineCode(lineCode),
    .tempCode(tempCode), .rampStep(rampStep), .switchEn(switchEn),
    .highSideInhibit(highSideInhibit), .dutyCeiling(dutyCeiling),
    .shutdownMode(shutdownMode)
  );

  // Reference model built from the requirements
  bit mUv, mLine, mSd, mOt, mOv;
  int mDiv, mRamp;

  function automatic bit modelOk();
    return mUv && mLine && !mSd && !mOt;
  endfunction
  function automatic bit expSw();
    return modelOk() && (mRamp >= 120);
  endfunction
  function automatic int expDuty();
    if (!expSw()) return 0;
    return 32 + (mRamp - 120) * 203 / 680;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mUv <= 0; mLine <= 0; mSd <= 0; mOt <= 0; mOv <= 0; mDiv <= 0; mRamp <= 0;
    end else begin
      automatic bit ok = modelOk();
      automatic int sum = mRamp + int'(rampStep);
      if (!mUv && supplyCode >= 880) mUv <= 1; else if (mUv && supplyCode < 830) mUv <= 0;
      if (!mLine && lineCode >= 330) mLine <= 1; else if (mLine && lineCode < 300) mLine <= 0;
      if (!mSd && lineCode < 55) mSd <= 1; else if (mSd && lineCode >= 75) mSd <= 0;
      if (!mOt && tempCode > 160) mOt <= 1; else if (mOt && tempCode < 130) mOt <= 0;
      mOv <= (int'(lineCode) + 30) > int'(supplyCode);
      if (!ok) begin
        mDiv <= 0; mRamp <= 0;
      end else if (mDiv == 3) begin
        mDiv <= 0; mRamp <= (sum > 800) ? 800 : sum;
      end else begin
        mDiv <= mDiv + 1;
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    cmp("switchEn", int'(switchEn), int'(expSw()));
    cmp("dutyCeiling", int'(dutyCeiling), expDuty());
    cmp("highSideInhibit", int'(highSideInhibit), int'(mOv));
    cmp("shutdownMode", int'(shutdownMode), int'(mSd));
  endtask

  // Drive at negedge, check at the next negedge
  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkAll();
    end
  endtask

  task automatic setIn(int s, int l, int t, int st);
    supplyCode = 12'(s); lineCode = 12'(l); tempCode = 8'(t); rampStep = 8'(st);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    tag = "R1";
    setIn(900, 400, 25, 10);
    repeat (3) @(negedge clk);
    checkAll();
    rst_n = 1'b1;
    run(1);
    tag = "R8"; run(60);           // dead zone, then switch on
    tag = "R7"; run(300);          // ramp to saturation
    tag = "R9"; run(20);           // at DUTY_MAX
    tag = "R2"; setIn(850, 400, 25, 10); run(10);  // inside band, holds
    setIn(820, 400, 25, 10); run(5);               // below clear level
    setIn(870, 400, 25, 10); run(10);              // still below set level
    tag = "R6"; setIn(880, 400, 25, 40); run(40);  // restart through dead zone
    tag = "R3"; setIn(900, 310, 25, 40); run(10);
    setIn(900, 290, 25, 40); run(5);
    setIn(900, 329, 25, 40); run(5);
    setIn(900, 330, 25, 40); run(40);
    tag = "R4"; setIn(900, 40, 25, 40); run(5);
    setIn(900, 70, 25, 40); run(5);
    setIn(900, 80, 25, 40); run(5);
    setIn(900, 400, 25, 40); run(40);
    tag = "R5"; setIn(900, 400, 160, 40); run(5);
    setIn(900, 400, 161, 40); run(5);
    setIn(900, 400, 140, 40); run(5);
    setIn(900, 400, 129, 40); run(40);
    tag = "R10"; setIn(900, 871, 25, 40); run(5);
    setIn(900, 870, 25, 40); run(5);
    setIn(900, 880, 25, 255); run(60);
    tag = "R11"; setIn(900, 400, 25, 255); run(3);
    tag = "R7"; setIn(900, 400, 25, 0); run(20);
    tag = "R6";
    for (int seg = 0; seg < 400; seg++) begin
      automatic int s = 800 + int'($urandom_range(150));
      automatic int l = ($urandom_range(3) == 0) ? int'($urandom_range(100))
                       : 280 + int'($urandom_range(640));
      automatic int t = 100 + int'($urandom_range(80));
      automatic int st = int'($urandom_range(255));
      if ($urandom_range(2) != 0) t = 25;
      setIn(s, l, t, st);
      run(1 + int'($urandom_range(120)));
    end
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule